// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home side of a directory-based cache coherence scheme for a multiprocessor whose memory is split across nodes. For every memory block it owns, it records a coherence state and a bit vector of the processors that currently cache that block. Caches send it three kinds of request: read miss, write miss and write back. Each request names the requesting processor and the block. The controller answers with point-to-point messages: data replies, invalidates, fetches and fetch-with-invalidate. It sends invalidates and fetches only to the caches marked in the vector, and it never broadcasts.

Requests are served strictly one at a time. A handshake on the request side (`reqValid`/`reqReady`) admits a request only while the controller is idle. When a block is owned exclusively by another cache, the controller sends that owner a fetch and waits for the owner's data on the fetch-response input. It stores that data into its memory array and then replies. The block's storage is a small internal array. Word i holds the value i after reset.

Top module: `dir_home_top`

## Requirements
- R1: After reset every block is uncached with an empty sharer vector, memory word i holds the value i, `reqReady` is high and `msgValid` is low.
- R2: A read miss (`reqKind`=0) to an uncached block sends a data reply (`msgKind`=0) carrying the stored word to the requester, and leaves the block shared with only the requester marked.
- R3: A write miss (`reqKind`=1) to an uncached block sends a data reply to the requester and leaves the block exclusive, owned by the requester.
- R4: A read miss to a shared block sends a data reply to the requester and adds the requester to the sharer vector without removing anyone.
- R5: A write miss to a shared block first sends one invalidate (`msgKind`=1) per cycle to each marked sharer other than the requester, in ascending processor order. It then sends the data reply and leaves the block exclusive to the requester. When the requester is the only sharer, no invalidate is sent.
- R6: A read miss to an exclusive block sends a fetch (`msgKind`=2) to the owner and waits for `fetchValid`. It writes `fetchData` into memory and replies to the requester with that data. The block becomes shared, with both the old owner and the requester marked.
- R7: A write miss to an exclusive block sends a fetch-with-invalidate (`msgKind`=3) to the owner and waits for `fetchValid`. It writes `fetchData` into memory, replies with that data, and leaves the block exclusive to the requester.
- R8: A write back (`reqKind`=2) from the owner of an exclusive block stores `reqData`, empties the sharer vector and makes the block uncached. No message is sent.
- R9: A write back from a processor that is not the exclusive owner of the block is ignored. No message is sent, and neither the memory nor the directory changes.
- R10: After `reqReady` admits a request, `reqReady` stays low until the request has finished, including every cycle spent waiting for a fetch response. Requests are processed in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqKind | input | 2 | 0 read miss, 1 write miss, 2 write back |
| reqProc | input | PROC_W | Requesting processor number |
| reqAddr | input | ADDR_W | Block index |
| reqData | input | DATA_W | Block data carried by a write back |
| fetchValid | input | 1 | Owner's fetched data present |
| fetchData | input | DATA_W | Block data returned by the owner |
| msgValid | output | 1 | Outgoing message valid this cycle |
| msgKind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-with-invalidate |
| msgDest | output | PROC_W | Destination processor |
| msgAddr | output | ADDR_W | Block index of the message |
| msgData | output | DATA_W | Block data (meaningful for data replies) |

## Verification
The hardest cases to reach are the transitions out of the exclusive state. Each one needs an earlier write miss to create an owner. After that, the bench has to act as the owner, answer the fetch after a chosen delay, and confirm that the reply carries the fetched word instead of the stale stored one. The stimulus builds a sharer set of three processors and has one of them write, which forces an ordered invalidate burst. It then reads and writes that exclusive block from other processors, inserting idle cycles before the fetch answer so that the busy window can be observed. A rejected write back is shown to have had no effect by a later read, which must return the earlier data.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;

  typedef enum logic [1:0] {
    ST_UNCACHED = 2'd0,
    ST_SHARED   = 2'd1,
    ST_EXCL     = 2'd2
  } dir_state_e;

  typedef enum logic [1:0] {
    REQ_RDMISS = 2'd0,
    REQ_WRMISS = 2'd1,
    REQ_WBACK  = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    MSG_DATA     = 2'd0,
    MSG_INVAL    = 2'd1,
    MSG_FETCH    = 2'd2,
    MSG_FETCHINV = 2'd3
  } msg_kind_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic      latchReq;
    logic      loadScan;
    logic      dropScan;
    logic      memFromFetch;
    logic      wbCommit;
    logic      updRead;
    logic      updWrite;
    logic      msgOn;
    msg_kind_e msgKind;
  } dp_ctl_t;

endpackage

// File: rtl/dir_home_dp.sv
module dir_home_dp
  import dir_home_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 16,
  parameter int DATA_W     = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dp_ctl_t                       ctl,
  input  logic [1:0]                    reqKind,
  input  logic [$clog2(NUM_PROCS)-1:0]  reqProc,
  input  logic [$clog2(NUM_BLOCKS)-1:0] reqAddr,
  input  logic [DATA_W-1:0]             reqData,
  input  logic [DATA_W-1:0]             fetchData,
  output dir_state_e                    entSt,
  output req_kind_e                     kindQ,
  output logic                          wbFromOwner,
  output logic                          othersNz,
  output logic                          scanMore,
  output logic                          msgValid,
  output logic [1:0]                    msgKind,
  output logic [$clog2(NUM_PROCS)-1:0]  msgDest,
  output logic [$clog2(NUM_BLOCKS)-1:0] msgAddr,
  output logic [DATA_W-1:0]             msgData
);
  localparam int PW = $clog2(NUM_PROCS);
  localparam int AW = $clog2(NUM_BLOCKS);

  dir_state_e           dirSt [NUM_BLOCKS];
  logic [NUM_PROCS-1:0] dirSh [NUM_BLOCKS];
  logic [DATA_W-1:0]    mem   [NUM_BLOCKS];

  logic [PW-1:0]        procQ;
  logic [AW-1:0]        addrQ;
  logic [DATA_W-1:0]    dataQ;
  logic [NUM_PROCS-1:0] scanVec;
  logic [NUM_PROCS-1:0] entSh;
  logic [NUM_PROCS-1:0] reqBit;
  logic [PW-1:0]        ownerIdx;
  logic [PW-1:0]        scanIdx;

  function automatic logic [PW-1:0] lowIdx(input logic [NUM_PROCS-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NUM_PROCS - 1; i >= 0; i--) begin
      if (v[i]) r = PW'(i);
    end
    return r;
  endfunction

  assign entSt       = dirSt[addrQ];
  assign entSh       = dirSh[addrQ];
  assign reqBit      = NUM_PROCS'(1) << procQ;
  assign ownerIdx    = lowIdx(entSh);
  assign scanIdx     = lowIdx(scanVec);
  assign wbFromOwner = (entSh == reqBit);
  assign othersNz    = |(entSh & ~reqBit);
  assign scanMore    = |(scanVec & (scanVec - NUM_PROCS'(1)));

  assign msgValid = ctl.msgOn;
  assign msgKind  = ctl.msgKind;
  assign msgAddr  = addrQ;
  assign msgData  = mem[addrQ];

  always_comb begin
    case (ctl.msgKind)
      MSG_DATA:  msgDest = procQ;
      MSG_INVAL: msgDest = scanIdx;
      default:   msgDest = ownerIdx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ   <= REQ_RDMISS;
      procQ   <= '0;
      addrQ   <= '0;
      dataQ   <= '0;
      scanVec <= '0;
    end else begin
      if (ctl.latchReq) begin
        kindQ <= req_kind_e'(reqKind);
        procQ <= reqProc;
        addrQ <= reqAddr;
        dataQ <= reqData;
      end
      if (ctl.loadScan)
        scanVec <= entSh & ~reqBit;
      else if (ctl.dropScan)
        scanVec <= scanVec & ~(NUM_PROCS'(1) << scanIdx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BLOCKS; i++) begin
        dirSt[i] <= ST_UNCACHED;
        dirSh[i] <= '0;
        mem[i]   <= DATA_W'(i);
      end
    end else begin
      if (ctl.memFromFetch) mem[addrQ] <= fetchData;
      if (ctl.wbCommit) begin
        mem[addrQ]   <= dataQ;
        dirSt[addrQ] <= ST_UNCACHED;
        dirSh[addrQ] <= '0;
      end
      if (ctl.updRead) begin
        dirSt[addrQ] <= ST_SHARED;
        dirSh[addrQ] <= entSh | reqBit;
      end
      if (ctl.updWrite) begin
        dirSt[addrQ] <= ST_EXCL;
        dirSh[addrQ] <= reqBit;
      end
    end
  end

  // R5: each invalidate retires exactly one pending sharer
  a_r5_scan_drops_one: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dropScan |=> ($countones(scanVec) == $countones($past(scanVec)) - 1));

  // R4 / R6: a read completion leaves the requester marked in a shared entry
  a_r4_reader_marked: assert property (@(posedge clk) disable iff (!rstN)
    ctl.updRead |=> (dirSt[addrQ] == ST_SHARED && dirSh[addrQ][procQ]));

  // R3 / R7: an exclusive entry names exactly one owner
  a_r3_single_owner: assert property (@(posedge clk) disable iff (!rstN)
    ctl.updWrite |=> (dirSt[addrQ] == ST_EXCL && $countones(dirSh[addrQ]) == 1));

  // R8: an accepted write back empties the entry
  a_r8_wb_uncached: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wbCommit |=> (dirSt[addrQ] == ST_UNCACHED && dirSh[addrQ] == '0));

  // R9: write backs never produce a message
  a_r9_wb_silent: assert property (@(posedge clk) disable iff (!rstN)
    ctl.msgOn |-> (kindQ != REQ_WBACK));

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_home_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       fetchValid,
  input  dir_state_e entSt,
  input  req_kind_e  kindQ,
  input  logic       wbFromOwner,
  input  logic       othersNz,
  input  logic       scanMore,
  output logic       reqReady,
  output dp_ctl_t    ctl
);
  typedef enum logic [2:0] {
    C_IDLE, C_LOOKUP, C_INVAL, C_FETCH, C_WAITF, C_REPLY
  } cstate_e;

  cstate_e st, nxt;

  always_comb begin
    ctl      = '0;
    nxt      = st;
    reqReady = 1'b0;
    case (st)
      C_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          nxt = C_LOOKUP;
        end
      end
      C_LOOKUP: begin
        case (kindQ)
          REQ_WBACK: begin
            if (entSt == ST_EXCL && wbFromOwner) ctl.wbCommit = 1'b1;
            nxt = C_IDLE;
          end
          REQ_RDMISS: nxt = (entSt == ST_EXCL) ? C_FETCH : C_REPLY;
          REQ_WRMISS: begin
            if (entSt == ST_EXCL) nxt = C_FETCH;
            else if (entSt == ST_SHARED && othersNz) begin
              ctl.loadScan = 1'b1;
              nxt = C_INVAL;
            end else nxt = C_REPLY;
          end
          default: nxt = C_IDLE;
        endcase
      end
      C_INVAL: begin
        ctl.msgOn    = 1'b1;
        ctl.msgKind  = MSG_INVAL;
        ctl.dropScan = 1'b1;
        if (!scanMore) nxt = C_REPLY;
      end
      C_FETCH: begin
        ctl.msgOn   = 1'b1;
        ctl.msgKind = (kindQ == REQ_WRMISS) ? MSG_FETCHINV : MSG_FETCH;
        nxt = C_WAITF;
      end
      C_WAITF: begin
        if (fetchValid) begin
          ctl.memFromFetch = 1'b1;
          nxt = C_REPLY;
        end
      end
      C_REPLY: begin
        ctl.msgOn   = 1'b1;
        ctl.msgKind = MSG_DATA;
        if (kindQ == REQ_RDMISS) ctl.updRead = 1'b1;
        else ctl.updWrite = 1'b1;
        nxt = C_IDLE;
      end
      default: nxt = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= C_IDLE;
    else st <= nxt;
  end

  // R10: an admitted request closes the door on the next cycle
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R6 / R7: while the owner has not answered, stay busy and silent
  a_r6_wait_for_owner: assert property (@(posedge clk) disable iff (!rstN)
    (st == C_WAITF && !fetchValid) |=> (!reqReady && !ctl.msgOn));

endmodule

// File: rtl/dir_home_top.sv
module dir_home_top
  import dir_home_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 16,
  parameter int DATA_W     = 32,
  localparam int PROC_W    = $clog2(NUM_PROCS),
  localparam int ADDR_W    = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [PROC_W-1:0] reqProc,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              fetchValid,
  input  logic [DATA_W-1:0] fetchData,
  output logic              msgValid,
  output logic [1:0]        msgKind,
  output logic [PROC_W-1:0] msgDest,
  output logic [ADDR_W-1:0] msgAddr,
  output logic [DATA_W-1:0] msgData
);
  dp_ctl_t    ctl;
  dir_state_e entSt;
  req_kind_e  kindQ;
  logic       wbFromOwner, othersNz, scanMore;

  dir_home_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fetchValid(fetchValid),
    .entSt(entSt), .kindQ(kindQ), .wbFromOwner(wbFromOwner),
    .othersNz(othersNz), .scanMore(scanMore), .reqReady(reqReady), .ctl(ctl)
  );

  dir_home_dp #(
    .NUM_PROCS(NUM_PROCS), .NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqKind(reqKind), .reqProc(reqProc),
    .reqAddr(reqAddr), .reqData(reqData), .fetchData(fetchData),
    .entSt(entSt), .kindQ(kindQ), .wbFromOwner(wbFromOwner),
    .othersNz(othersNz), .scanMore(scanMore), .msgValid(msgValid),
    .msgKind(msgKind), .msgDest(msgDest), .msgAddr(msgAddr), .msgData(msgData)
  );

endmodule

// File: tb/dir_home_top_tb_top.sv
module dir_home_top_tb_top;
  localparam int NP = 4;
  localparam int NB = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid, reqReady, fetchValid, msgValid;
  logic [1:0]    reqKind, msgKind;
  logic [1:0]    reqProc, msgDest;
  logic [3:0]    reqAddr, msgAddr;
  logic [DW-1:0] reqData, fetchData, msgData;

  always #2 clk = ~clk;

  dir_home_top #(.NUM_PROCS(NP), .NUM_BLOCKS(NB), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqProc(reqProc), .reqAddr(reqAddr), .reqData(reqData),
    .fetchValid(fetchValid), .fetchData(fetchData), .msgValid(msgValid),
    .msgKind(msgKind), .msgDest(msgDest), .msgAddr(msgAddr), .msgData(msgData)
  );

  typedef struct { int kind; int dest; int data; } exp_t;
  exp_t expQ[$];
  int   mSt[NB];
  int   mSh[NB];
  int   mMem[NB];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic void push(input int k, input int d, input int v);
    exp_t e;
    e.kind = k; e.dest = d; e.data = v;
    expQ.push_back(e);
  endfunction

  function automatic int owner(input int v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  // behavioural reference: states 0 uncached, 1 shared, 2 exclusive
  function automatic void model(input int k, input int p, input int a,
                                input int d, input int fd);
    int bitP = 1 << p;
    if (k == 0) begin
      if (mSt[a] == 2) begin
        push(2, owner(mSh[a]), 0);
        mMem[a] = fd;
      end
      push(0, p, mMem[a]);
      mSh[a] = mSh[a] | bitP;
      mSt[a] = 1;
    end else if (k == 1) begin
      if (mSt[a] == 2) begin
        push(3, owner(mSh[a]), 0);
        mMem[a] = fd;
      end else if (mSt[a] == 1) begin
        for (int i = 0; i < NP; i++)
          if (mSh[a][i] && i != p) push(1, i, 0);
      end
      push(0, p, mMem[a]);
      mSh[a] = bitP;
      mSt[a] = 2;
    end else begin
      if (mSt[a] == 2 && mSh[a] == bitP) begin
        mMem[a] = d; mSh[a] = 0; mSt[a] = 0;
      end
    end
  endfunction

  task automatic runReq(input int k, input int p, input int a, input int d,
                        input int fd, input int fdelay, input string req);
    exp_t e;
    model(k, p, a, d, fd);
    @(negedge clk);
    check(reqReady == 1'b1, "R10", "ready before request", reqReady, 1);
    reqValid = 1'b1; reqKind = 2'(k); reqProc = 2'(p);
    reqAddr = 4'(a); reqData = DW'(d);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R10", "ready after accept", reqReady, 0);
    while (!reqReady) begin
      if (msgValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, req, "unexpected message kind", msgKind, -1);
        end else begin
          e = expQ.pop_front();
          check(msgKind == 2'(e.kind), req, "message kind", msgKind, e.kind);
          check(msgDest == 2'(e.dest), req, "message dest", msgDest, e.dest);
          check(msgAddr == 4'(a), req, "message addr", msgAddr, a);
          if (e.kind == 0)
            check(msgData == DW'(e.data), req, "reply data", msgData, e.data);
          if (e.kind >= 2) begin
            for (int w = 0; w < fdelay; w++) begin
              @(negedge clk);
              check(!reqReady && !msgValid, "R10", "busy while owner pending",
                    {reqReady, msgValid}, 0);
            end
            fetchValid = 1'b1; fetchData = DW'(fd);
            @(negedge clk);
            fetchValid = 1'b0;
            continue;
          end
        end
      end
      @(negedge clk);
    end
    check(expQ.size() == 0, req, "messages missing", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqKind = '0; reqProc = '0; reqAddr = '0;
    reqData = '0; fetchValid = 1'b0; fetchData = '0;
    for (int i = 0; i < NB; i++) begin mSt[i] = 0; mSh[i] = 0; mMem[i] = i; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    check(msgValid == 1'b0, "R1", "no message after reset", msgValid, 0);

    runReq(0, 0, 3, 0, 0, 0, "R2");          // uncached read, returns word 3
    runReq(0, 2, 3, 0, 0, 0, "R4");          // shared read adds P2
    runReq(0, 3, 3, 0, 0, 0, "R4");
    runReq(1, 2, 3, 0, 0, 0, "R5");          // invalidates to P0 then P3
    runReq(0, 1, 3, 0, 32'hAA, 3, "R6");     // fetch from owner P2
    runReq(1, 0, 3, 0, 0, 0, "R5");          // invalidates to P1 then P2
    runReq(1, 3, 3, 0, 32'hBB, 2, "R7");     // fetch-invalidate to P0
    runReq(2, 1, 3, 32'h11, 0, 0, "R9");     // non-owner write back ignored
    runReq(2, 3, 3, 32'hCC, 0, 0, "R8");     // owner write back
    runReq(0, 1, 3, 0, 0, 0, "R8");          // uncached again, sees 0xCC
    runReq(1, 1, 5, 0, 0, 0, "R3");          // uncached write miss
    runReq(2, 1, 7, 32'h55, 0, 0, "R9");     // write back to uncached block
    runReq(0, 0, 7, 0, 0, 0, "R9");          // still holds 7
    runReq(0, 2, 9, 0, 0, 0, "R2");
    runReq(1, 2, 9, 0, 0, 0, "R5");          // sole sharer: no invalidate
    runReq(0, 0, 5, 0, 32'h77, 1, "R6");     // owner P1 of block 5

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog R10 actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule